// File: doc/BRIEF.md
# Shared Interrupt Distributor with Per-Line Routing

This block sits between the external interrupt sources of a small multi-core cluster and the per-core interrupt interfaces. Each shared line carries an identifier that starts at 32, so line `i` has identifier `32 + i`. For every line the block applies a programmable sense mode, keeps a pending state, and offers the line to one selected core or to all cores. The outputs are one request vector per core.

A core takes a line by presenting its identifier on its claim port. The grant comes back in the same cycle. From then on the line is in service and belongs to that core. It is withdrawn from every core until the owning core reports completion for the same identifier. Software reaches the configuration through a 32-bit register bank: a global enable word, packed 2-bit sense fields, and one routing word per line.

Each line runs a four-state machine:
- `LN_IDLE` moves to `LN_PEND` on a trigger event: the selected edge, or the active level.
- `LN_PEND` moves to `LN_BUSY` when a core is granted. In a level mode it falls back to `LN_IDLE` if the level goes away first.
- `LN_BUSY` moves to `LN_BUSY_REARM` when a fresh edge arrives. On completion by the owner it goes to `LN_IDLE`, or to `LN_PEND` if a level-mode input is still active.
- `LN_BUSY_REARM` moves to `LN_PEND` on completion by the owner.

Top module: `shared_irq_dist`

## Requirements
- R1: After reset the enable bit, every sense field and every routing word read as 0, every bit of `core_req` is 0 and every bit of `claim_grant` is 0.
- R2: The enable is bit 0 of the word at address 0x0. While it is 0, `core_req` is all zero and no claim is granted. A line that became pending while the block was disabled appears as a request once the enable is set.
- R3: The sense field of line `i` sits in the word at 0x100 + 4*(i/16), bits [2*(i%16)+1 : 2*(i%16)]. A read returns exactly the stored fields. Addresses beyond the last sense word read 0.
- R4: The routing word of line `i` is at 0x1000 + 4*i. Bit 31 and bits [7:0] are stored. All other bits read 0. Addresses beyond the last line read 0.
- R5: Sense code 0 makes the line pending while its input is 1. Code 1 makes it pending while its input is 0. An unclaimed level line whose input goes inactive is withdrawn after one clock.
- R6: Sense code 2 latches pending on a 0-to-1 input change and code 3 on a 1-to-0 change. The opposite change has no effect. A latched edge stays pending after the input returns.
- R7: A routing word with bit 31 set and bits [7:0] naming core `k` below the core count forwards the pending line only to bit `k*NLINE + i` of `core_req`.
- R8: A routing word equal to 0 forwards the line to every core. When several cores claim it in the same cycle, the lowest-numbered core is granted. The line is then withdrawn from all cores.
- R9: A routing word with bit 31 set and an index at or above the core count, or with bit 31 clear and a nonzero index, forwards the line to no core.
- R10: A claim is granted, in the same cycle, only when the claimed identifier names a line that is currently requested to that core. After the grant the line's request bits drop on the next clock.
- R11: Only a completion from the owning core carrying the line's identifier ends service. Completions from other cores are ignored.
- R12: An edge that arrives while an edge-mode line is in service is remembered. The line becomes pending again at the clock that accepts the owner's completion.
- R13: A level-mode line whose input is still active when its owner completes becomes pending again at the same clock that accepts the completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq_lines | input | NLINE | Shared interrupt inputs, bit `i` is identifier 32+i |
| claim_vld | input | NCORE | Per-core claim strobe |
| claim_id | input | NCORE*IDW | Per-core claimed identifier, core `c` at `[c*IDW +: IDW]` |
| claim_grant | output | NCORE | Per-core grant of the claim in the same cycle |
| done_vld | input | NCORE | Per-core completion strobe |
| done_id | input | NCORE*IDW | Per-core completed identifier |
| core_req | output | NCORE*NLINE | Request vectors, core `c` line `i` at bit `c*NLINE+i` |

## Verification
The assertions expect reset to be held for at least one clock and every input to change only away from the rising edge. They also expect each core to present at most one claim and one completion per cycle, which the port shape already forces. The stimulus drives all inputs on the falling edge. The random phase issues no claims, so no line is in service while its routing word is rewritten. Sense fields are changed only while the affected inputs sit at their inactive value, so no unintended request is left behind for later checks.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam int SID_ID_BASE   = 32;
    localparam int SID_IDX_W     = 8;
    localparam int SID_OFS_CTRL  = 'h0000;
    localparam int SID_OFS_TRIG  = 'h0100;
    localparam int SID_OFS_ROUTE = 'h1000;

    typedef enum logic [1:0] {
        TRG_LEVEL_HI = 2'd0,
        TRG_LEVEL_LO = 2'd1,
        TRG_RISE     = 2'd2,
        TRG_FALL     = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        LN_IDLE       = 2'd0,
        LN_PEND       = 2'd1,
        LN_BUSY       = 2'd2,
        LN_BUSY_REARM = 2'd3
    } line_state_e;

endpackage

// File: rtl/sid_regs.sv
module sid_regs
    import sid_pkg::*;
#(
    parameter int NLINE = 32,
    parameter int AW    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [AW-1:0]               bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic                        en_o,
    output logic [2*NLINE-1:0]          trig_o,
    output logic [NLINE-1:0]            rflag_o,
    output logic [NLINE*SID_IDX_W-1:0]  ridx_o
);

    localparam int NTW = (NLINE + 15) / 16;
    localparam int TW  = NTW * 32;

    logic                        en_q;
    logic [TW-1:0]               trig_q;
    logic [NLINE-1:0]            rflag_q;
    logic [NLINE*SID_IDX_W-1:0]  ridx_q;

    function automatic logic [31:0] trig_word_mask(input int w);
        logic [31:0] m;
        for (int b = 0; b < 32; b++) begin
            m[b] = ((32 * w + b) < (2 * NLINE));
        end
        return m;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            trig_q  <= '0;
            rflag_q <= '0;
            ridx_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == AW'(SID_OFS_CTRL)) begin
                en_q <= bus_wdata[0];
            end
            for (int w = 0; w < NTW; w++) begin
                if (bus_addr == AW'(SID_OFS_TRIG + 4 * w)) begin
                    trig_q[32*w +: 32] <= bus_wdata & trig_word_mask(w);
                end
            end
            for (int l = 0; l < NLINE; l++) begin
                if (bus_addr == AW'(SID_OFS_ROUTE + 4 * l)) begin
                    rflag_q[l]                     <= bus_wdata[31];
                    ridx_q[l*SID_IDX_W +: SID_IDX_W] <= bus_wdata[SID_IDX_W-1:0];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(SID_OFS_CTRL)) begin
            bus_rdata[0] = en_q;
        end
        for (int w = 0; w < NTW; w++) begin
            if (bus_addr == AW'(SID_OFS_TRIG + 4 * w)) begin
                bus_rdata = trig_q[32*w +: 32];
            end
        end
        for (int l = 0; l < NLINE; l++) begin
            if (bus_addr == AW'(SID_OFS_ROUTE + 4 * l)) begin
                bus_rdata = {rflag_q[l], {(31-SID_IDX_W){1'b0}},
                             ridx_q[l*SID_IDX_W +: SID_IDX_W]};
            end
        end
    end

    assign en_o    = en_q;
    assign trig_o  = trig_q[2*NLINE-1:0];
    assign rflag_o = rflag_q;
    assign ridx_o  = ridx_q;

endmodule

// File: rtl/sid_route_dec.sv
module sid_route_dec
    import sid_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                 flag_i,
    input  logic [SID_IDX_W-1:0] idx_i,
    output logic [NCORE-1:0]     tgt_o
);

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            if (flag_i) begin
                tgt_o[c] = (idx_i == SID_IDX_W'(c));
            end else begin
                tgt_o[c] = (idx_i == '0);
            end
        end
    end

endmodule

// File: rtl/sid_line.sv
module sid_line
    import sid_pkg::*;
#(
    parameter int NCORE   = 4,
    parameter int IDW     = 8,
    parameter int LINE_ID = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  irq_i,
    input  logic [1:0]            trig_i,
    input  logic [NCORE-1:0]      tgt_i,
    input  logic [NCORE-1:0]      claim_vld_i,
    input  logic [NCORE*IDW-1:0]  claim_id_i,
    input  logic [NCORE-1:0]      done_vld_i,
    input  logic [NCORE*IDW-1:0]  done_id_i,
    output logic [1:0]            st_o,
    output logic [NCORE-1:0]      req_o,
    output logic [NCORE-1:0]      grant_o
);

    localparam int OW = (NCORE > 1) ? $clog2(NCORE) : 1;

    line_state_e   state_q, state_d;
    logic          prev_q;
    logic [OW-1:0] owner_q, owner_d;

    trig_mode_e    mode;
    logic          is_edge;
    logic          lvl_act;
    logic          edge_evt;
    logic [NCORE-1:0] hit;
    logic          win_found;
    logic [OW-1:0] win_idx;
    logic          done_hit;

    assign mode    = trig_mode_e'(trig_i);
    assign is_edge = trig_i[1];

    always_comb begin
        lvl_act  = 1'b0;
        edge_evt = 1'b0;
        unique case (mode)
            TRG_LEVEL_HI: lvl_act  = irq_i;
            TRG_LEVEL_LO: lvl_act  = !irq_i;
            TRG_RISE:     edge_evt = irq_i && !prev_q;
            TRG_FALL:     edge_evt = !irq_i && prev_q;
        endcase
    end

    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            hit[c] = en_i && (state_q == LN_PEND) && tgt_i[c] && claim_vld_i[c]
                     && (claim_id_i[c*IDW +: IDW] == IDW'(LINE_ID));
        end
        win_found = 1'b0;
        win_idx   = '0;
        for (int c = NCORE - 1; c >= 0; c--) begin
            if (hit[c]) begin
                win_found = 1'b1;
                win_idx   = OW'(c);
            end
        end
    end

    always_comb begin
        done_hit = 1'b0;
        for (int c = 0; c < NCORE; c++) begin
            if ((owner_q == OW'(c)) && done_vld_i[c]
                && (done_id_i[c*IDW +: IDW] == IDW'(LINE_ID))) begin
                done_hit = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            LN_IDLE: begin
                if (is_edge ? edge_evt : lvl_act) begin
                    state_d = LN_PEND;
                end
            end
            LN_PEND: begin
                if (win_found) begin
                    state_d = LN_BUSY;
                    owner_d = win_idx;
                end else if (!is_edge && !lvl_act) begin
                    state_d = LN_IDLE;
                end
            end
            LN_BUSY: begin
                if (done_hit) begin
                    state_d = (!is_edge && lvl_act) ? LN_PEND : LN_IDLE;
                end else if (is_edge && edge_evt) begin
                    state_d = LN_BUSY_REARM;
                end
            end
            LN_BUSY_REARM: begin
                if (done_hit) begin
                    state_d = LN_PEND;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            owner_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            prev_q  <= irq_i;
        end
    end

    always_comb begin
        req_o   = '0;
        grant_o = '0;
        if (en_i && (state_q == LN_PEND)) begin
            req_o = tgt_i;
        end
        if (win_found) begin
            grant_o[win_idx] = 1'b1;
        end
    end

    assign st_o = state_q;

endmodule

// File: rtl/shared_irq_dist.sv
module shared_irq_dist
    import sid_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NLINE = 32,
    parameter int AW    = 16,
    parameter int IDW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [AW-1:0]            bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NLINE-1:0]         irq_lines,
    input  logic [NCORE-1:0]         claim_vld,
    input  logic [NCORE*IDW-1:0]     claim_id,
    output logic [NCORE-1:0]         claim_grant,
    input  logic [NCORE-1:0]         done_vld,
    input  logic [NCORE*IDW-1:0]     done_id,
    output logic [NCORE*NLINE-1:0]   core_req
);

    logic                        en_w;
    logic [2*NLINE-1:0]          trig_flat;
    logic [NLINE-1:0]            rflag;
    logic [NLINE*SID_IDX_W-1:0]  ridx;
    logic [2*NLINE-1:0]          st_flat;
    logic [NLINE*NCORE-1:0]      line_grant_flat;
    logic [NLINE*NCORE-1:0]      line_req_flat;

    sid_regs #(
        .NLINE (NLINE),
        .AW    (AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_o      (en_w),
        .trig_o    (trig_flat),
        .rflag_o   (rflag),
        .ridx_o    (ridx)
    );

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        logic [NCORE-1:0] tgt;

        sid_route_dec #(
            .NCORE (NCORE)
        ) u_dec (
            .flag_i (rflag[l]),
            .idx_i  (ridx[l*SID_IDX_W +: SID_IDX_W]),
            .tgt_o  (tgt)
        );

        sid_line #(
            .NCORE   (NCORE),
            .IDW     (IDW),
            .LINE_ID (SID_ID_BASE + l)
        ) u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (en_w),
            .irq_i       (irq_lines[l]),
            .trig_i      (trig_flat[2*l +: 2]),
            .tgt_i       (tgt),
            .claim_vld_i (claim_vld),
            .claim_id_i  (claim_id),
            .done_vld_i  (done_vld),
            .done_id_i   (done_id),
            .st_o        (st_flat[2*l +: 2]),
            .req_o       (line_req_flat[l*NCORE +: NCORE]),
            .grant_o     (line_grant_flat[l*NCORE +: NCORE])
        );

        for (genvar c = 0; c < NCORE; c++) begin : g_core
            assign core_req[c*NLINE + l] = line_req_flat[l*NCORE + c];
        end
    end

    always_comb begin
        claim_grant = '0;
        for (int l = 0; l < NLINE; l++) begin
            claim_grant = claim_grant | line_grant_flat[l*NCORE +: NCORE];
        end
    end

endmodule

// File: rtl/shared_irq_dist_chk.sv
module shared_irq_dist_chk #(
    parameter int NCORE = 4,
    parameter int NLINE = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en_w,
    input logic [NCORE*NLINE-1:0]  core_req,
    input logic [2*NLINE-1:0]      st_flat,
    input logic [2*NLINE-1:0]      trig_flat,
    input logic [NLINE-1:0]        rflag,
    input logic [NLINE*NCORE-1:0]  line_grant_flat
);

    assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |-> (core_req == '0))
        else $error("R2: request while disabled");

    for (genvar l = 0; l < NLINE; l++) begin : g_ln
        logic [NCORE-1:0] col;
        logic [1:0]       st;
        logic [NCORE-1:0] gnt;

        always_comb begin
            for (int c = 0; c < NCORE; c++) begin
                col[c] = core_req[c*NLINE + l];
            end
        end
        assign st  = st_flat[2*l +: 2];
        assign gnt = line_grant_flat[l*NCORE +: NCORE];

        assert_single_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rflag[l] |-> $onehot0(col))
            else $error("R7: directed line reaches several cores");

        assert_one_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt))
            else $error("R8: line granted to several cores");

        assert_withdrawn_R10: assert property (@(posedge clk) disable iff (!rst_n)
            st[1] |-> (col == '0))
            else $error("R10: line in service still requested");

        assert_edge_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ((st == 2'd1) && trig_flat[2*l+1]) |=> (st != 2'd0))
            else $error("R6: latched edge lost");

        assert_rearm_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (st == 2'd3) |=> (st != 2'd0))
            else $error("R12: remembered edge lost");
    end

endmodule

bind shared_irq_dist shared_irq_dist_chk #(
    .NCORE (NCORE),
    .NLINE (NLINE)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_w            (en_w),
    .core_req        (core_req),
    .st_flat         (st_flat),
    .trig_flat       (trig_flat),
    .rflag           (rflag),
    .line_grant_flat (line_grant_flat)
);

// File: tb/tb_shared_irq_dist.sv
`timescale 1ns/1ps
module tb_shared_irq_dist;

    localparam int NC = 4;
    localparam int NL = 32;
    localparam int IW = 8;
    localparam real TCK = 8.0;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic [15:0]       bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [NL-1:0]     irq_lines;
    logic [NC-1:0]     claim_vld;
    logic [NC*IW-1:0]  claim_id;
    logic [NC-1:0]     claim_grant;
    logic [NC-1:0]     done_vld;
    logic [NC*IW-1:0]  done_id;
    logic [NC*NL-1:0]  core_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] route_mdl [NL];

    always #(TCK/2) clk = ~clk;

    shared_irq_dist #(.NCORE(NC), .NLINE(NL), .AW(16), .IDW(IW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
        .claim_vld(claim_vld), .claim_id(claim_id), .claim_grant(claim_grant),
        .done_vld(done_vld), .done_id(done_id), .core_req(core_req)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        bus_wr    = 1'b1;
        bus_addr  = 16'(addr);
        bus_wdata = data;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int addr, input logic [31:0] exp);
        bus_addr = 16'(addr);
        #1;
        check(tag, 128'(bus_rdata), 128'(exp));
    endtask

    function automatic logic [127:0] rbit(input int c, input int l);
        logic [127:0] v = '0;
        v[c*NL + l] = 1'b1;
        return v;
    endfunction

    function automatic logic [127:0] all_cores(input int l);
        logic [127:0] v = '0;
        for (int c = 0; c < NC; c++) v[c*NL + l] = 1'b1;
        return v;
    endfunction

    function automatic logic [127:0] model_req(input logic [31:0] lv);
        logic [127:0] v = '0;
        for (int l = 0; l < NL; l++) begin
            if (lv[l]) begin
                for (int c = 0; c < NC; c++) begin
                    if (route_mdl[l][31] ? (route_mdl[l][7:0] == 8'(c))
                                         : (route_mdl[l][7:0] == 8'd0))
                        v[c*NL + l] = 1'b1;
                end
            end
        end
        return v;
    endfunction

    task automatic set_claim(input int c, input int id);
        claim_vld[c] = 1'b1;
        claim_id[c*IW +: IW] = 8'(id);
    endtask

    task automatic pulse_done(input int c, input int id);
        done_vld[c] = 1'b1;
        done_id[c*IW +: IW] = 8'(id);
        tick();
        done_vld = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(TCK * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        irq_lines = '0; claim_vld = '0; claim_id = '0; done_vld = '0; done_id = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd_check("R1 enable", 'h0, 32'h0);
        rd_check("R1 sense word", 'h100, 32'h0);
        rd_check("R1 route word", 'h1000, 32'h0);
        check("R1 core_req", core_req, '0);
        check("R1 claim_grant", 128'(claim_grant), '0);

        // R3 sense field storage and readback
        for (int i = 0; i < 10; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            wr('h100, a);
            wr('h104, b);
            rd_check("R3 word0", 'h100, a);
            rd_check("R3 word1", 'h104, b);
        end
        rd_check("R3 beyond last word", 'h108, 32'h0);
        wr('h100, 32'h0);
        wr('h104, 32'h0);
        tick();

        // R4 routing word masking
        wr('h1000 + 4*5, 32'hFFFF_FFFF);
        rd_check("R4 masked bits", 'h1000 + 4*5, 32'h8000_00FF);
        rd_check("R4 beyond last line", 'h1000 + 4*NL, 32'h0);
        wr('h1000 + 4*5, 32'h0);

        // R2: pending while disabled stays hidden
        wr('h1000, 32'h8000_0001);
        irq_lines[0] = 1'b1;
        tick(); tick();
        check("R2 no request while disabled", core_req, '0);
        set_claim(1, 32);
        #1 check("R2 no grant while disabled", 128'(claim_grant), '0);
        tick();
        claim_vld = '0;
        wr('h0, 32'h1);
        check("R2/R7 request after enable to core 1 only", core_req, rbit(1, 0));

        // R10 claim matching
        set_claim(2, 32);
        #1 check("R10 non-target core not granted", 128'(claim_grant), '0);
        claim_vld = '0;
        set_claim(1, 33);
        #1 check("R10 wrong identifier not granted", 128'(claim_grant), '0);
        set_claim(1, 32);
        #1 check("R10 target core granted", 128'(claim_grant), 128'(4'b0010));
        tick();
        claim_vld = '0;
        check("R10 request dropped after grant", core_req, '0);

        // R11 / R13 completion
        pulse_done(0, 32);
        check("R11 completion from other core ignored", core_req, '0);
        pulse_done(1, 32);
        check("R13 level still active re-pends", core_req, rbit(1, 0));
        set_claim(1, 32);
        tick();
        claim_vld = '0;
        irq_lines[0] = 1'b0;
        pulse_done(1, 32);
        tick();
        check("R11 owner completion returns to idle", core_req, '0);

        // R5 active-high withdrawal
        irq_lines[0] = 1'b1;
        tick();
        check("R5 active-high pends", core_req, rbit(1, 0));
        irq_lines[0] = 1'b0;
        tick();
        check("R5 unclaimed level withdrawn", core_req, '0);

        // R5 / R8 active-low on an automatic line
        wr('h100, 32'h0000_0004);
        tick();
        check("R5/R8 active-low to all cores", core_req, all_cores(1));
        irq_lines[1] = 1'b1;
        tick();
        check("R5 active-low withdrawn", core_req, '0);

        // R6 / R8 / R11 / R12 rising edge on an automatic line
        wr('h100, 32'h0000_0024);
        irq_lines[2] = 1'b1;
        tick();
        irq_lines[2] = 1'b0;
        tick();
        check("R6 rising edge latched", core_req, all_cores(2));
        set_claim(3, 34);
        set_claim(2, 34);
        #1 check("R8 lowest core wins", 128'(claim_grant), 128'(4'b0100));
        tick();
        claim_vld = '0;
        check("R8 withdrawn from all cores", core_req, '0);
        pulse_done(3, 34);
        irq_lines[2] = 1'b1;
        tick();
        irq_lines[2] = 1'b0;
        tick();
        check("R11 non-owner completion kept line in service", core_req, '0);
        pulse_done(2, 34);
        check("R12 edge during service re-pends", core_req, all_cores(2));
        set_claim(0, 34);
        tick();
        claim_vld = '0;
        pulse_done(0, 34);
        check("R12 second service finished", core_req, '0);

        // R6 falling edge directed line
        wr('h100, 32'h0000_00E4);
        wr('h1000 + 4*3, 32'h8000_0003);
        irq_lines[3] = 1'b1;
        tick(); tick();
        check("R6 rising change ignored in falling mode", core_req, '0);
        irq_lines[3] = 1'b0;
        tick();
        check("R6 falling edge latched", core_req, rbit(3, 3));
        tick();
        check("R6 latched edge held", core_req, rbit(3, 3));
        set_claim(3, 35);
        #1 check("R10 directed grant", 128'(claim_grant), 128'(4'b1000));
        tick();
        claim_vld = '0;
        pulse_done(3, 35);
        check("R11 falling line idle", core_req, '0);

        // R9 invalid routes, R7 valid route
        wr('h1000 + 4*4, 32'h8000_0007);
        irq_lines[4] = 1'b1;
        tick(); tick();
        check("R9 index out of range", core_req, '0);
        wr('h1000 + 4*4, 32'h0000_0002);
        tick();
        check("R9 flag clear nonzero", core_req, '0);
        wr('h1000 + 4*4, 32'h8000_0002);
        check("R7 directed to core 2", core_req, rbit(2, 4));
        irq_lines[4] = 1'b0;
        tick();

        // random routing with level-high sensing
        irq_lines = '0;
        wr('h100, 32'h0);
        wr('h104, 32'h0);
        tick();
        for (int it = 0; it < 20; it++) begin
            for (int l = 0; l < NL; l++) begin
                int kind = int'($urandom % 4);
                logic [31:0] junk = $urandom & 32'h7FFF_FF00;
                logic [31:0] val;
                case (kind)
                    0: val = 32'h0;
                    1: val = 32'h8000_0000 | 32'($urandom % 4);
                    2: val = 32'h8000_0000 | 32'(4 + $urandom % 4);
                    default: val = 32'(($urandom % 255) + 1);
                endcase
                route_mdl[l] = val;
                wr('h1000 + 4*l, val | junk);
            end
            begin
                int pick = int'($urandom % NL);
                rd_check("R4 random readback", 'h1000 + 4*pick, route_mdl[pick]);
            end
            irq_lines = $urandom;
            tick(); tick();
            check("R7/R8/R9 random routing", core_req, model_req(irq_lines));
        end

        finish_run();
    end

endmodule